// File: doc/BRIEF.md
# Short-Cycled X1 Ranging Chip Generator

This block produces the X1 component of a precision ranging code: one chip for each clock cycle in which the chip enable is high. It holds two 12-stage linear feedback shift registers. Each register is reloaded with its seed before it reaches the end of its natural 4095-chip sequence. Register A is cut to 4092 chips and register B to 4093 chips, so B slips one chip behind A on every A cycle. The X1 chip is the XOR of the two register outputs.

A counter tracks the completed register-A cycles. After a programmable number of them (3750 by default, which gives 15,345,000 chips), a new period starts and both registers are reloaded together. Because 3750 A cycles are not a whole number of B cycles, register B stops on the last chip of its second-to-last cycle. It stays there until A closes the period, so the two registers line up again exactly at every period boundary.

A downstream ranging-code combiner would take `x1_o` and use `epoch_o` as the period marker.

Top module: `x1_gen`

## Requirements
- R1: A synchronous active-high reset puts the block in its state for the first chip of a period: `epoch_o`=1, `cycle_o`=0, and `x1_o` equals the XOR of the two seed MSBs (0).
- R2: Register A is a 12-stage shifter, stage 1 toward stage 12, with stage 12 as its output. Its new stage-1 bit is the XOR of stages 6, 8, 11 and 12. Its seed, written stage 12 first down to stage 1, is 001001001000.
- R3: Register B shifts the same way. Its feedback is the XOR of stages 1, 2, 5, 8, 9, 10, 11 and 12. Its seed, stage 12 first, is 010101010100.
- R4: `x1_o` is the XOR of the stage-12 outputs of registers A and B for the current chip.
- R5: Register A is reloaded with its seed after every A_LEN (4092) chips. `cycle_o` counts the completed A cycles within the period.
- R6: Register B is reloaded with its seed after every B_LEN (4093) chips, except as stated in R7.
- R7: On its last chip of cycle number CYCLES-1 (1-based), register B holds its state. It keeps holding until the period ends.
- R8: After CYCLES complete A cycles, both registers reload together and `cycle_o` returns to 0. `epoch_o` is high during the first chip of each period and low during every other chip.
- R9: While `chip_en` is low, no state changes, so `x1_o`, `epoch_o` and `cycle_o` hold their values.
- R10: `cycle_o` never exceeds CYCLES-1 and advances by exactly one at each A reload inside a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Advances the generator by one chip |
| x1_o | output | 1 | Current X1 chip |
| epoch_o | output | 1 | High during the first chip of a period |
| cycle_o | output | $clog2(CYCLES) | Completed register-A cycles in this period |

## Verification
Three events share one chip boundary: the last A reload of a period, the period restart, and the release of register B from its hold. The restart has to win over both a normal A reload and the frozen B state. The bench uses a reduced period of four A cycles and sweeps more than two full periods chip by chip. It compares every chip with sequences it builds on its own from the polynomials and seeds, and it indexes those sequences by chip number using modular arithmetic. Inside the sweep it inserts enable gaps and applies a reset in mid-period.

// File: rtl/x1_gen_pkg.sv
package x1_gen_pkg;

    localparam int SR_W = 12;

    typedef logic [SR_W-1:0] sr_t;

    // bit k-1 corresponds to stage k; bit 11 is stage 12 (output)
    localparam sr_t A_TAPS = 12'b1100_1010_0000;
    localparam sr_t B_TAPS = 12'b1111_1001_0011;
    localparam sr_t A_SEED = 12'b001001001000;
    localparam sr_t B_SEED = 12'b010101010100;

    typedef struct packed {
        logic reload;
        logic step;
    } sr_ctl_t;

    function automatic sr_t sr_next(sr_t s, sr_t taps);
        return {s[SR_W-2:0], ^(s & taps)};
    endfunction

endpackage

// File: rtl/x1_sr.sv
module x1_sr
    import x1_gen_pkg::*;
#(
    parameter sr_t SEED = A_SEED,
    parameter sr_t TAPS = A_TAPS
) (
    input  logic    clk,
    input  logic    rst,
    input  sr_ctl_t ctl,
    output sr_t     state
);

    always_ff @(posedge clk) begin
        if (rst)             state <= SEED;
        else if (ctl.reload) state <= SEED;
        else if (ctl.step)   state <= sr_next(state, TAPS);
    end

endmodule

// File: rtl/x1_cnt.sv
module x1_cnt #(
    parameter int MAXV = 4091,
    localparam int W = (MAXV < 1) ? 1 : $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] val
);

    always_ff @(posedge clk) begin
        if (rst)      val <= '0;
        else if (clr) val <= '0;
        else if (inc) val <= val + 1'b1;
    end

endmodule

// File: rtl/x1_gen.sv
module x1_gen
    import x1_gen_pkg::*;
#(
    parameter int A_LEN  = 4092,
    parameter int B_LEN  = 4093,
    parameter int CYCLES = 3750,
    localparam int AI_W = $clog2(A_LEN),
    localparam int BI_W = $clog2(B_LEN),
    localparam int CW   = $clog2(CYCLES),
    localparam int BC_MAX = CYCLES - 2,
    localparam int BC_W = (BC_MAX < 1) ? 1 : $clog2(BC_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_en,
    output logic          x1_o,
    output logic          epoch_o,
    output logic [CW-1:0] cycle_o
);

    logic [AI_W-1:0] a_idx;
    logic [BI_W-1:0] b_idx;
    logic [CW-1:0]   a_cyc;
    logic [BC_W-1:0] b_cyc;
    sr_t             a_state, b_state;
    sr_ctl_t         a_ctl, b_ctl;

    logic a_last, b_last, a_wrap, period_end, b_freeze, b_adv, b_wrap;

    always_comb begin
        a_last     = (a_idx == AI_W'(A_LEN - 1));
        b_last     = (b_idx == BI_W'(B_LEN - 1));
        a_wrap     = chip_en & a_last;
        period_end = a_wrap & (a_cyc == CW'(CYCLES - 1));
        b_freeze   = b_last & (b_cyc == BC_W'(BC_MAX));
        b_adv      = chip_en & ~b_freeze;
        b_wrap     = b_adv & b_last;
        a_ctl.reload = a_wrap;
        a_ctl.step   = chip_en;
        b_ctl.reload = b_wrap | period_end;
        b_ctl.step   = b_adv;
    end

    x1_cnt #(.MAXV(A_LEN - 1)) u_a_idx (
        .clk(clk), .rst(rst), .inc(chip_en), .clr(a_wrap), .val(a_idx));

    x1_cnt #(.MAXV(CYCLES - 1)) u_a_cyc (
        .clk(clk), .rst(rst), .inc(a_wrap), .clr(period_end), .val(a_cyc));

    x1_cnt #(.MAXV(B_LEN - 1)) u_b_idx (
        .clk(clk), .rst(rst), .inc(b_adv), .clr(b_wrap | period_end), .val(b_idx));

    x1_cnt #(.MAXV(BC_MAX)) u_b_cyc (
        .clk(clk), .rst(rst), .inc(b_wrap), .clr(period_end), .val(b_cyc));

    x1_sr #(.SEED(A_SEED), .TAPS(A_TAPS)) u_sr_a (
        .clk(clk), .rst(rst), .ctl(a_ctl), .state(a_state));

    x1_sr #(.SEED(B_SEED), .TAPS(B_TAPS)) u_sr_b (
        .clk(clk), .rst(rst), .ctl(b_ctl), .state(b_state));

    assign x1_o    = a_state[SR_W-1] ^ b_state[SR_W-1];
    assign epoch_o = (a_idx == '0) && (a_cyc == '0);
    assign cycle_o = a_cyc;

endmodule

// File: rtl/x1_gen_chk.sv
module x1_gen_chk
    import x1_gen_pkg::*;
#(
    parameter int A_LEN  = 4092,
    parameter int CYCLES = 3750,
    parameter int AI_W   = 12,
    parameter int CW     = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            chip_en,
    input logic            x1_o,
    input logic            epoch_o,
    input logic [CW-1:0]   cycle_o,
    input logic [AI_W-1:0] a_idx,
    input logic            b_freeze,
    input sr_t             a_state,
    input sr_t             b_state
);

    // R8
    epoch_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_en && a_idx == AI_W'(A_LEN - 1) && cycle_o == CW'(CYCLES - 1)) |=> epoch_o);

    // R8
    epoch_reload_chk: assert property (@(posedge clk) disable iff (rst)
        epoch_o |-> (a_state == A_SEED && b_state == B_SEED));

    // R8
    epoch_single_chk: assert property (@(posedge clk) disable iff (rst)
        (epoch_o && chip_en) |=> !epoch_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> ($stable(x1_o) && $stable(epoch_o) && $stable(cycle_o)));

    // R7
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (b_freeze && chip_en && !(a_idx == AI_W'(A_LEN - 1) && cycle_o == CW'(CYCLES - 1)))
        |=> $stable(b_state));

    // R10
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_en && a_idx == AI_W'(A_LEN - 1) && cycle_o != CW'(CYCLES - 1))
        |=> cycle_o == $past(cycle_o) + 1'b1);

    // R10
    cycle_range_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_o <= CW'(CYCLES - 1));

endmodule

bind x1_gen x1_gen_chk #(
    .A_LEN(A_LEN), .CYCLES(CYCLES), .AI_W(AI_W), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst), .chip_en(chip_en), .x1_o(x1_o), .epoch_o(epoch_o),
    .cycle_o(cycle_o), .a_idx(a_idx), .b_freeze(b_freeze),
    .a_state(a_state), .b_state(b_state)
);

// File: tb/x1_gen_tb.sv
module x1_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int A_LEN  = 4092;
    localparam int B_LEN  = 4093;
    localparam int CYC    = 4;
    localparam int CW     = $clog2(CYC);
    localparam int PERIOD = A_LEN * CYC;
    localparam int B_RUN  = (CYC - 1) * B_LEN;
    localparam int ITERS  = 40000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_en = 1'b0;
    logic x1_o, epoch_o;
    logic [CW-1:0] cycle_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit seq_a [4095];
    bit seq_b [4095];

    always #(CLK_PERIOD/2) clk = ~clk;

    x1_gen #(.A_LEN(A_LEN), .B_LEN(B_LEN), .CYCLES(CYC)) u_dut (
        .clk(clk), .rst(rst), .chip_en(chip_en),
        .x1_o(x1_o), .epoch_o(epoch_o), .cycle_o(cycle_o));

    // R2 / R3: natural sequences built from tap lists and seed strings
    task automatic build_seq(input logic [11:0] seed, input int ntap, input int taps [8],
                             output bit seq [4095]);
        bit st [1:12];
        for (int k = 1; k <= 12; k++) st[k] = seed[k-1];
        for (int n = 0; n < 4095; n++) begin
            bit fb = 1'b0;
            seq[n] = st[12];
            for (int t = 0; t < ntap; t++) fb ^= st[taps[t]];
            for (int k = 12; k > 1; k--) st[k] = st[k-1];
            st[1] = fb;
        end
    endtask

    function automatic bit exp_x1(int n);
        int bp = (n < B_RUN) ? (n % B_LEN) : (B_LEN - 1);
        return seq_a[n % A_LEN] ^ seq_b[bp];
    endfunction

    task automatic check(input string req, input int act, input int exp, input int n);
        total++;
        if (act != exp) begin
            bad++;
            if (bad < 20)
                $display("FAIL %s chip=%0d actual=%0d expected=%0d", req, n, act, exp);
        end
    endtask

    task automatic check_all(input int n);
        string rq;
        if (n >= B_RUN && n < B_RUN + 3)      rq = "R7";
        else if (n % B_LEN == 0 && n < B_RUN) rq = "R6";
        else if (n % A_LEN == 0)              rq = "R5";
        else                                  rq = "R4";
        check(rq, int'(x1_o), int'(exp_x1(n)), n);
        check("R8", int'(epoch_o), (n == 0) ? 1 : 0, n);
        check("R10", int'(cycle_o), n / A_LEN, n);
    endtask

    initial begin
        int ta [8] = '{6, 8, 11, 12, 0, 0, 0, 0};
        int tb [8] = '{1, 2, 5, 8, 9, 10, 11, 12};
        int n = 0;
        build_seq(12'b001001001000, 4, ta, seq_a);
        build_seq(12'b010101010100, 8, tb, seq_b);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", int'(epoch_o), 1, 0);
        check("R1", int'(cycle_o), 0, 0);
        check("R1", int'(x1_o), 0, 0);
        for (int it = 0; it < ITERS; it++) begin
            bit en;
            @(negedge clk);
            if (it == 30000) begin
                rst = 1'b1;
                chip_en = 1'b0;
                @(negedge clk);
                @(negedge clk);
                rst = 1'b0;
                n = 0;
                // R1: mid-period reset returns to first chip
                check("R1", int'(epoch_o), 1, n);
                check("R1", int'(cycle_o), 0, n);
            end
            // R9: when previous enable was low, same n is expected again
            check_all(n);
            en = (it % 7) != 3;
            chip_en = en;
            if (en) n = (n + 1) % PERIOD;
        end
        @(negedge clk);
        chip_en = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule